// File: doc/BRIEF.md
# Boot Image Trailer Validator

This block inspects a firmware image while it is copied into on-chip memory from an external serial memory. The image is made of 256-byte sectors. It arrives as a stream of bytes, each tagged with its sector index and its offset within the sector. Nobody states the image length in advance. The block finds the end of the image itself, from a four-byte trailer that sits in the top four offsets of the final sector. Offset FCh carries an 8-bit checksum. Offset FDh carries the sector count. Offsets FEh and FFh carry the signature bytes A5h and 5Ah.

At the close of every sector, the block tests the three trailer fields. The first sector whose fields all agree ends the image. The block then compares the stored checksum with a modulo-256 sum of every image byte before the checksum byte, zero padding included. On a match it releases the processor from reset and hands the boot-select pin back to general use. The checksum fails if the bytes do not match. The image also fails if no trailer appears within a parameterised number of sectors. Either failure keeps the processor held. A synchronous clear restarts validation.

Top module: `boot_image_check`

## Requirements
- R1: After reset, done_o, pass_o, cpu_run_o and gpio_free_o are all 0.
- R2: The checksum is the modulo-256 sum of every accepted byte from the first one up to and including offset FBh of the final sector. An image passes when this sum equals the byte at offset FCh of that sector.
- R3: A sector is the final one when its bytes at offsets FEh and FFh are A5h and 5Ah, and its byte at FDh equals sector_i + 1. The first sector that meets all three conditions ends the image.
- R4: A sector whose trailer fields fail any test is ordinary image data. Its bytes at FCh to FFh count towards the checksum, and scanning goes on.
- R5: A trailer that is found with a wrong checksum ends validation with pass_o = 0 and cpu_run_o = 0.
- R6: done_o is a one-cycle pulse. It is high in the cycle after the clock edge that accepts the offset FFh byte of the deciding sector.
- R7: On a pass, pass_o, cpu_run_o and gpio_free_o rise together with done_o and stay high until clear.
- R8: If the sector with index MAX_SECTORS-1 (default 126) ends without a valid trailer, done_o pulses with pass_o = 0.
- R9: After the result, further bytes are ignored. No new done_o pulse appears, and the outputs keep their values.
- R10: clear_i returns the outputs to their reset values and restarts the sum. A byte presented in the same cycle as clear_i is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous restart of validation |
| byte_valid_i | input | 1 | A byte is presented this cycle |
| byte_i | input | 8 | Image byte |
| sector_i | input | SEC_W (7) | Sector index of the byte, from 0 |
| offset_i | input | 8 | Offset of the byte within its sector |
| done_o | output | 1 | One-cycle pulse when the result is decided |
| pass_o | output | 1 | Held result: the image passed |
| cpu_run_o | output | 1 | Held processor reset release |
| gpio_free_o | output | 1 | Held flag: the boot-select pin is free as a GPIO |

## Verification
The assertions check four things on every cycle. done_o is a single pulse that directly follows an accepted offset FFh byte. The result is frozen while the block holds it. A clear zeroes the outputs and the running sum. Only the bench scenarios can show the rest: the sum value itself, that the first matching trailer wins over a decoy with the wrong count, the sector-size boundary at 252 and 253 firmware bytes, and the failure after the sector limit. The bench checks each of these against images it builds and sums itself.

// File: rtl/boot_chk_pkg.sv
package boot_chk_pkg;
  localparam logic [7:0] SIG_FIRST = 8'hA5;
  localparam logic [7:0] SIG_LAST  = 8'h5A;
  localparam logic [7:0] OFF_CKSUM = 8'hFC;
  localparam logic [7:0] OFF_COUNT = 8'hFD;
  localparam logic [7:0] OFF_SIG0  = 8'hFE;
  localparam logic [7:0] OFF_SIG1  = 8'hFF;

  typedef enum logic {
    ST_SCAN,
    ST_HOLD
  } chk_state_e;
endpackage

// File: rtl/boot_sum_acc.sv
module boot_sum_acc
  import boot_chk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              take_i,
  input  logic [7:0]        offset_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [DATA_W-1:0] snap_o
);
  logic [DATA_W-1:0] sum_q, snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      snap_q <= '0;
    end else if (clear_i) begin
      sum_q  <= '0;
      snap_q <= '0;
    end else if (take_i) begin
      sum_q <= sum_q + byte_i;
      // freeze the sum of everything before the checksum slot
      if (offset_i == OFF_CKSUM) snap_q <= sum_q;
    end
  end

  assign snap_o = snap_q;

  p_clear_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sum_q == '0 && snap_q == '0));
endmodule

// File: rtl/boot_trailer_det.sv
module boot_trailer_det
  import boot_chk_pkg::*;
#(
  parameter int SEC_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             take_i,
  input  logic [7:0]       offset_i,
  input  logic [7:0]       byte_i,
  input  logic [SEC_W-1:0] sector_i,
  input  logic [7:0]       snap_i,
  output logic             sec_end_o,
  output logic             hit_o,
  output logic             ck_ok_o
);
  logic [7:0] ck_q, cnt_q, sig0_q;
  logic [8:0] want_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q   <= '0;
      cnt_q  <= '0;
      sig0_q <= '0;
    end else if (clear_i) begin
      ck_q   <= '0;
      cnt_q  <= '0;
      sig0_q <= '0;
    end else if (take_i) begin
      if (offset_i == OFF_CKSUM) ck_q   <= byte_i;
      if (offset_i == OFF_COUNT) cnt_q  <= byte_i;
      if (offset_i == OFF_SIG0)  sig0_q <= byte_i;
    end
  end

  assign want_cnt  = 9'(sector_i) + 9'd1;
  assign sec_end_o = take_i && (offset_i == OFF_SIG1);
  assign hit_o     = sec_end_o && (sig0_q == SIG_FIRST) && (byte_i == SIG_LAST)
                     && ({1'b0, cnt_q} == want_cnt);
  assign ck_ok_o   = (ck_q == snap_i);
endmodule

// File: rtl/boot_image_check.sv
module boot_image_check
  import boot_chk_pkg::*;
#(
  parameter int MAX_SECTORS = 127,
  localparam int SEC_W = $clog2(MAX_SECTORS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic [SEC_W-1:0] sector_i,
  input  logic [7:0]       offset_i,
  output logic             done_o,
  output logic             pass_o,
  output logic             cpu_run_o,
  output logic             gpio_free_o
);
  chk_state_e state_q;
  logic       take, sec_end, hit, ck_ok, limit, done_q, pass_q;
  logic [7:0] snap;

  assign take  = byte_valid_i && !clear_i && (state_q == ST_SCAN);
  assign limit = ({1'b0, sector_i} >= (SEC_W + 1)'(MAX_SECTORS - 1));

  boot_sum_acc #(.DATA_W(8)) i_sum (
    .clk_i, .rst_ni, .clear_i, .take_i(take), .offset_i, .byte_i, .snap_o(snap)
  );

  boot_trailer_det #(.SEC_W(SEC_W)) i_trl (
    .clk_i, .rst_ni, .clear_i, .take_i(take), .offset_i, .byte_i, .sector_i,
    .snap_i(snap), .sec_end_o(sec_end), .hit_o(hit), .ck_ok_o(ck_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SCAN;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else if (clear_i) begin
      state_q <= ST_SCAN;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sec_end && (hit || limit)) begin
        state_q <= ST_HOLD;
        done_q  <= 1'b1;
        pass_q  <= hit && ck_ok;
      end
    end
  end

  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign cpu_run_o   = pass_q;
  assign gpio_free_o = pass_q;

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_ff_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(byte_valid_i && !clear_i && offset_i == OFF_SIG1));
  p_hold_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !clear_i) |=> ($stable(pass_o) && !done_o));
  p_clear_outputs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!done_o && !pass_o && !cpu_run_o));
endmodule

// File: tb/test_boot_image_check.sv
module test_boot_image_check;
  localparam int MAXS = 127;
  logic clk = 0, rst_n = 0, clear = 0, bvalid = 0;
  logic [7:0] bdata = 0, off = 0;
  logic [6:0] sec = 0;
  logic done, pass, run, gfree;
  int checks = 0, fails = 0;
  logic [7:0] mem [0:32767];
  bit exp_q[$];

  always #2.5 clk = ~clk;

  boot_image_check #(.MAX_SECTORS(MAXS)) i_boot_image_check (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .byte_valid_i(bvalid),
    .byte_i(bdata), .sector_i(sec), .offset_i(off), .done_o(done),
    .pass_o(pass), .cpu_run_o(run), .gpio_free_o(gfree)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected result per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected done", 1, 0);
      else begin
        automatic bit e = exp_q.pop_front();
        check(pass == e && run == e && gfree == e, "R7 result outputs",
              {pass, run, gfree}, {e, e, e});
      end
    end
  end

  // firmware of n bytes; fake puts a decoy trailer (wrong count) in sector 0
  task automatic build(input int n, input int seed, input bit fake,
                       input logic [7:0] ck_err, output int total);
    int s;
    logic [7:0] sum;
    s = (n + 4 + 255) / 256;
    total = s * 256;
    for (int i = 0; i < total; i++) mem[i] = (i < n) ? 8'((i * 37 + seed) ^ (i >> 3)) : 8'h00;
    if (fake && n >= 256) begin
      mem[253] = 8'h05; mem[254] = 8'hA5; mem[255] = 8'h5A;
    end
    sum = 0;
    for (int i = 0; i < total - 4; i++) sum = sum + mem[i];
    mem[total-4] = sum ^ ck_err;
    mem[total-3] = 8'(s);
    mem[total-2] = 8'hA5;
    mem[total-1] = 8'h5A;
  endtask

  task automatic stream(input int nbytes);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      bvalid = 1; bdata = mem[i]; sec = 7'(i >> 8); off = 8'(i);
    end
    @(negedge clk);
    bvalid = 0;
  endtask

  task automatic run_image(input int n, input int seed, input bit fake,
                           input logic [7:0] ck_err, input string req);
    int total;
    build(n, seed, fake, ck_err, total);
    exp_q.push_back(ck_err == 0);
    stream(total);
    check(done == 1, {req, " R6 done after last byte"}, done, 1);
    @(negedge clk);
    check(done == 0 && exp_q.size() == 0, {req, " R6 single pulse"}, done, 0);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
    check(!done && !pass && !run && !gfree, "R10 clear outputs", {done, pass, run, gfree}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !pass && !run && !gfree, "R1 reset state", {done, pass, run, gfree}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!done && !pass && !run && !gfree, "R1 after release", {done, pass, run, gfree}, 0);

    // R2 R3: 618-byte image, three sectors
    begin
      int t;
      build(618, 11, 0, 8'h00, t);
      check(t == 768 && mem[765] == 8'h03 && mem[617+1] == 8'h00, "R3 layout", t, 768);
    end
    run_image(618, 11, 0, 8'h00, "R2");
    check(pass && run && gfree, "R7 held after pass", {pass, run, gfree}, 7);

    // R9: bytes after result are ignored
    stream(768);
    repeat (2) @(negedge clk);
    check(pass && run && !done, "R9 no effect after result", {pass, run, done}, 6);

    // R5: checksum mismatch
    do_clear();
    run_image(100, 3, 0, 8'h40, "R5");
    check(!run && !pass, "R5 cpu held", run, 0);

    // R4: decoy trailer in sector 0
    do_clear();
    run_image(600, 77, 1, 8'h00, "R4");

    // R10: byte with clear is discarded, then 252-byte single-sector image
    @(negedge clk); clear = 1; bvalid = 1; bdata = 8'h77; sec = 0; off = 0;
    @(negedge clk); clear = 0; bvalid = 0;
    run_image(252, 5, 0, 8'h00, "R10 R2 boundary 252");

    do_clear();
    run_image(253, 9, 0, 8'h00, "R3 boundary 253");

    do_clear();
    run_image(0, 0, 0, 8'h00, "R2 empty firmware");

    // R8: no trailer within the sector limit
    do_clear();
    for (int i = 0; i < MAXS * 256; i++) mem[i] = 8'h00;
    exp_q.push_back(0);
    stream(MAXS * 256);
    check(done == 1 && !pass && !run, "R8 limit fail", {done, pass, run}, 4);
    @(negedge clk);
    check(exp_q.size() == 0 && !done, "R8 single result", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule